// File: doc/BRIEF.md
# DDR Converter Output Deserializer

This block receives the double-data-rate output bus of a 14-bit data converter and rebuilds whole samples in the receiver clock domain. The transmitter drives seven data lanes and an over/underrange lane, and forwards a clock. Every lane carries two bits of one sample: one bit while the forwarded clock is low and the other while it is high. The overrange lane is meaningful only during the low phase. In the high phase the transmitter forces it to zero, so the block never uses that value.

The receiver clock runs several times faster than the forwarded clock. The block registers the forwarded clock and the lanes together and finds each transition of the forwarded clock. It then samples the lanes a fixed number of receiver cycles into each phase, well away from the transitions. A low-phase capture (even bits plus flag) is held until the next high-phase capture (odd bits). The two halves are then merged into one 14-bit word with its flag, and a one-cycle valid strobe marks the new word.

Top module: `ddr_out_deser`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `word_valid`, `word_out` and `ovr_out` are all zero.
- R2: In every assembled word, bit 2k of `word_out` is the value lane k held in the low phase and bit 2k+1 is the value lane k held in the following high phase (k = 0..LANES-1).
- R3: `ovr_out` equals the value of `ovr_lane` sampled in the low phase of the pair. The high-phase value of `ovr_lane` has no effect.
- R4: Each low phase followed by a high phase yields exactly one `word_valid` pulse that lasts one receiver cycle. `word_out` and `ovr_out` hold their value between pulses.
- R5: Let the first receiver rising edge that samples `fwd_clk` high be edge 1. `word_valid` rises on edge CAP_OFS+2 (edge 4 with the defaults).
- R6: A high phase with no low-phase capture since the last word, including the first high phase after reset, produces no word.
- R7: While `fwd_clk` stays at one level, no further word is produced. A low-phase capture held through a stall pairs with the next high phase.
- R8: Each phase's lanes are taken from the receiver edge that comes CAP_OFS edges after the edge that first sees the new `fwd_clk` level. Lane values on every other edge of the phase have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock, faster than the forwarded clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_clk | input | 1 | Forwarded clock from the transmitter |
| lane_in | input | LANES (7) | DDR data lanes; lane k carries bits 2k and 2k+1 |
| ovr_lane | input | 1 | Over/underrange lane, valid in the low phase only |
| word_out | output | 2*LANES (14) | Reassembled sample |
| ovr_out | output | 1 | Over/underrange flag of the sample |
| word_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
A word is due on receiver edge CAP_OFS+2, counted from the edge that first registers the forwarded clock high. The bench changes inputs on falling edges of the receiver clock and counts falling edges from each forwarded-clock transition it drives. It expects the strobe and data exactly four falling edges after the high-phase transition and requires the strobe to be low on every other falling edge of the pair. The jitter scenario places wrong lane values on the first and last edge of each phase. This confirms that only the mid-phase edge is sampled.

// File: rtl/ddr_rx_pkg.sv
package ddr_rx_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} fwd_phase_e;
endpackage

// File: rtl/ddr_rx_phase_track.sv
module ddr_rx_phase_track
  import ddr_rx_pkg::*;
#(
  parameter int LANES   = 7,
  parameter int CAP_OFS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwd_clk,
  input  logic [LANES-1:0] lane_in,
  input  logic             ovr_lane,
  output logic [LANES-1:0] lane_q,
  output logic             ovr_q,
  output logic             lo_cap,
  output logic             hi_cap
);
  localparam int CNT_MAX = CAP_OFS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             fclk_q, fclk_d;
  logic [CNT_W-1:0] since_edge;
  logic             edge_seen, at_point;
  fwd_phase_e       cur_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      fclk_q     <= 1'b0;
      fclk_d     <= 1'b0;
      lane_q     <= '0;
      ovr_q      <= 1'b0;
      since_edge <= CNT_W'(CNT_MAX);
    end else begin
      fclk_q <= fwd_clk;
      fclk_d <= fclk_q;
      lane_q <= lane_in;
      ovr_q  <= ovr_lane;
      if (edge_seen)
        since_edge <= CNT_W'(1);
      else if (since_edge != CNT_W'(CNT_MAX))
        since_edge <= since_edge + 1'b1;
    end
  end

  always_comb begin
    edge_seen = fclk_q ^ fclk_d;
    cur_ph    = fclk_q ? PH_HIGH : PH_LOW;
    at_point  = !edge_seen && (since_edge == CNT_W'(CAP_OFS));
    lo_cap    = at_point && (cur_ph == PH_LOW);
    hi_cap    = at_point && (cur_ph == PH_HIGH);
  end

  // R8: one capture per phase, never two strobes back to back
  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    (lo_cap || hi_cap) |=> !(lo_cap || hi_cap));
endmodule

// File: rtl/ddr_rx_pair.sv
module ddr_rx_pair #(
  parameter int LANES = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lo_cap,
  input  logic             hi_cap,
  input  logic [LANES-1:0] lane_q,
  input  logic             ovr_q,
  output logic [LANES-1:0] even_q,
  output logic             ovr_lo,
  output logic             pair_go
);
  logic have_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      even_q  <= '0;
      ovr_lo  <= 1'b0;
      have_lo <= 1'b0;
    end else if (lo_cap) begin
      even_q  <= lane_q;
      ovr_lo  <= ovr_q;
      have_lo <= 1'b1;
    end else if (pair_go) begin
      have_lo <= 1'b0;
    end
  end

  assign pair_go = hi_cap && have_lo;

  // R6: a consumed low half cannot be reused
  assert_pair_clear_R6: assert property (@(posedge clk) disable iff (rst)
    pair_go |=> !have_lo);
  // R7: held low half survives a stall untouched
  assert_lo_kept_R7: assert property (@(posedge clk) disable iff (rst)
    !lo_cap |=> $stable(even_q) && $stable(ovr_lo));
endmodule

// File: rtl/ddr_rx_interleave.sv
module ddr_rx_interleave #(
  parameter int LANES = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pair_go,
  input  logic [LANES-1:0]   even_q,
  input  logic [LANES-1:0]   odd_in,
  input  logic               ovr_lo,
  output logic [2*LANES-1:0] word_out,
  output logic               ovr_out,
  output logic               word_valid
);
  localparam int SMP_W = 2 * LANES;

  logic [SMP_W-1:0] mixed;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign mixed[2*k]   = even_q[k];
    assign mixed[2*k+1] = odd_in[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out   <= '0;
      ovr_out    <= 1'b0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= pair_go;
      if (pair_go) begin
        word_out <= mixed;
        ovr_out  <= ovr_lo;
      end
    end
  end

  // R4: outputs hold between words
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !pair_go |=> $stable(word_out) && $stable(ovr_out));
endmodule

// File: rtl/ddr_out_deser.sv
module ddr_out_deser #(
  parameter int LANES   = 7,
  parameter int CAP_OFS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fwd_clk,
  input  logic [LANES-1:0]   lane_in,
  input  logic               ovr_lane,
  output logic [2*LANES-1:0] word_out,
  output logic               ovr_out,
  output logic               word_valid
);
  logic [LANES-1:0] lane_q, even_q;
  logic             ovr_q, ovr_lo, lo_cap, hi_cap, pair_go;

  ddr_rx_phase_track #(.LANES(LANES), .CAP_OFS(CAP_OFS)) u_track (
    .clk(clk), .rst(rst), .fwd_clk(fwd_clk), .lane_in(lane_in),
    .ovr_lane(ovr_lane), .lane_q(lane_q), .ovr_q(ovr_q),
    .lo_cap(lo_cap), .hi_cap(hi_cap));

  ddr_rx_pair #(.LANES(LANES)) u_pair (
    .clk(clk), .rst(rst), .lo_cap(lo_cap), .hi_cap(hi_cap),
    .lane_q(lane_q), .ovr_q(ovr_q), .even_q(even_q), .ovr_lo(ovr_lo),
    .pair_go(pair_go));

  ddr_rx_interleave #(.LANES(LANES)) u_mix (
    .clk(clk), .rst(rst), .pair_go(pair_go), .even_q(even_q),
    .odd_in(lane_q), .ovr_lo(ovr_lo), .word_out(word_out),
    .ovr_out(ovr_out), .word_valid(word_valid));

  // R4: the strobe lasts a single cycle
  assert_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);
  // R6: a high-phase capture with no pending low half yields nothing
  assert_orphan_R6: assert property (@(posedge clk) disable iff (rst)
    (hi_cap && !pair_go) |=> !word_valid);
endmodule

// File: tb/test_ddr_out_deser.sv
module test_ddr_out_deser;
  localparam int LANES = 7;
  localparam int SMP_W = 2 * LANES;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fwd_clk = 1'b0;
  logic [LANES-1:0] lane_in = '0;
  logic             ovr_lane = 1'b0;
  logic [SMP_W-1:0] word_out;
  logic             ovr_out, word_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  ddr_out_deser #(.LANES(LANES), .CAP_OFS(2)) i_ddr_out_deser (
    .clk(clk), .rst(rst), .fwd_clk(fwd_clk), .lane_in(lane_in),
    .ovr_lane(ovr_lane), .word_out(word_out), .ovr_out(ovr_out),
    .word_valid(word_valid));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [SMP_W-1:0] build(input logic [LANES-1:0] ev,
                                             input logic [LANES-1:0] od);
    logic [SMP_W-1:0] w;
    for (int k = 0; k < LANES; k++) begin
      w[2*k]   = ev[k];
      w[2*k+1] = od[k];
    end
    return w;
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Drives one low half then one high half; called at a falling clk edge.
  task automatic drive_pair(input logic [LANES-1:0] ev, input logic [LANES-1:0] od,
                            input logic ov_lo, input logic ov_hi, input bit jit);
    logic [SMP_W-1:0] exp_w;
    exp_w = build(ev, od);
    fwd_clk = 1'b0;
    lane_in = jit ? ~ev : ev;
    ovr_lane = jit ? ~ov_lo : ov_lo;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      chk(word_valid == 1'b0, "R4 low-phase strobe", 32'(word_valid), 0);
      if (jit && i == 1) begin lane_in = ev; ovr_lane = ov_lo; end
      if (jit && i == 3) begin lane_in = ~ev; ovr_lane = ~ov_lo; end
    end
    @(negedge clk);
    fwd_clk = 1'b1;
    lane_in = jit ? ~od : od;
    ovr_lane = ov_hi;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      chk(word_valid == 1'b0, "R5 early strobe", 32'(word_valid), 0);
      if (jit && i == 1) lane_in = od;
      if (jit && i == 3) lane_in = ~od;
    end
    @(negedge clk);
    chk(word_valid == 1'b1, "R5 strobe on edge 4", 32'(word_valid), 1);
    chk(word_out == exp_w, jit ? "R8 mid-phase sampling" : "R2 bit interleave",
        32'(word_out), 32'(exp_w));
    chk(ovr_out == ov_lo, "R3 overflow from low phase", 32'(ovr_out), 32'(ov_lo));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(word_valid == 1'b0 && word_out == '0 && ovr_out == 1'b0, "R1 reset state",
        {16'(word_out), 15'd0, word_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(word_valid == 1'b0 && word_out == '0, "R1 after release",
        32'(word_out), 0);
  endtask

  task automatic t_orphan();
    fwd_clk = 1'b1;
    lane_in = 7'h55;
    ovr_lane = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(word_valid == 1'b0, "R6 high phase without low", 32'(word_valid), 0);
    end
  endtask

  task automatic t_patterns();
    drive_pair('0, '0, 1'b0, 1'b0, 1'b0);
    drive_pair('1, '0, 1'b0, 1'b0, 1'b0);
    drive_pair('0, '1, 1'b0, 1'b0, 1'b0);
    drive_pair(7'h2A, 7'h15, 1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 40; n++)
      drive_pair(LANES'($urandom), LANES'($urandom), 1'($urandom), 1'b0, 1'b0);
  endtask

  task automatic t_overflow();
    drive_pair(7'h11, 7'h22, 1'b1, 1'b0, 1'b0);
    drive_pair(7'h33, 7'h44, 1'b0, 1'b1, 1'b0);  // R3 high-phase flag ignored
    drive_pair(7'h7F, 7'h7F, 1'b1, 1'b1, 1'b0);
    drive_pair(7'h01, 7'h40, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_jitter();
    for (int n = 0; n < 10; n++)
      drive_pair(LANES'($urandom), LANES'($urandom), 1'($urandom), 1'b1, 1'b1);
  endtask

  task automatic t_stall();
    logic [SMP_W-1:0] exp_w;
    exp_w = build(7'h4C, 7'h33);
    fwd_clk = 1'b0;
    lane_in = 7'h4C;
    ovr_lane = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(word_valid == 1'b0, "R7 no word while low held", 32'(word_valid), 0);
    end
    fwd_clk = 1'b1;
    lane_in = 7'h33;
    ovr_lane = 1'b0;
    repeat (4) @(negedge clk);
    chk(word_valid == 1'b1 && word_out == exp_w && ovr_out == 1'b1,
        "R7 held low pairs with next high", {16'(word_out), 15'd0, word_valid},
        {16'(exp_w), 16'd1});
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(word_valid == 1'b0 && word_out == exp_w, "R7 no word while high held",
          32'(word_out), 32'(exp_w));
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_orphan();
    t_patterns();
    t_overflow();
    t_jitter();
    t_stall();
    drive_pair(7'h5A, 7'h25, 1'b1, 1'b0, 1'b0);
    finish_up();
  end
endmodule